// File: doc/BRIEF.md
# CPU Clock Mode Transition Controller

This block holds the control word that picks the CPU clock source and the divide ratio in a small microcontroller. It decodes that word into an operating mode and drives a source select, a divide select and a flash wait-state setting to the clock tree. The four sources are the main oscillator, a PLL, an on-chip oscillator and a sub-clock oscillator. The divider can give 1, 2, 4, 8 or 16.

Software writes the whole word in one cycle. The block checks each write against the mode-transition rules before it accepts it. Those rules cover bit ordering, oscillator readiness, the PLL interlocks and the oscillation-stop lock. A legal write updates the word and the mode at the next clock edge. An illegal write leaves every bit as it was and raises a one-cycle error pulse with a reason code. The states of the mode machine are HIGH (main clock divided by 1), MID (main clock divided by 2 to 16), PLL, ROC (on-chip oscillator), ROC_LP (on-chip oscillator with the main clock stopped), LOW (sub-clock) and LOWPWR (sub-clock with the main clock stopped).

The transitions and their names:
- **enter_pll** goes from HIGH to PLL. **leave_pll** goes from PLL to HIGH.
- **div_step** moves between HIGH and MID.
- **to_roc** and **from_roc** move between the main clock and ROC or ROC_LP.
- **to_sub** and **from_sub** move between the main clock or ROC and LOW or LOWPWR.
- **stop_main** and **start_main** move between LOW and LOWPWR, and between ROC and ROC_LP.

Top module: `clkmode_ctrl`

Control word bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | div_b | divider select, low bit |
| 1 | div_a | divider select, high bit |
| 2 | div8 | 1 = divide by 8 |
| 3 | sub_sel | 1 = sub-clock drives the CPU |
| 4 | main_stop | 1 = main oscillator stopped |
| 5 | roc_sel | 1 = on-chip oscillator drives the CPU |
| 6 | pll_on | 1 = PLL running |
| 7 | pll_sel | 1 = PLL output selected |
| 8 | wait1 | 1 = one wait state, 0 = two |
| 9 | hi_drive | 1 = high oscillator drive |
| 10 | osd_en | 1 = oscillation-stop detection armed |

## Requirements
- R1: Reset gives control word 0x204 (div8=1, hi_drive=1, all other bits 0). This is mode MID (code 1), source main (0) and divide select 3.
- R2: When div8=1, divide select (log2 of the ratio) is 3. When div8=0, the pair {div_a,div_b} maps 00→0, 01→1, 10→2 and 11→4. Mode is HIGH (0) when the ratio is 1 and MID (1) otherwise.
- R3: The mode is picked in priority order: sub_sel, then roc_sel, then pll_on with pll_sel, then the main clock.
  - sub_sel gives LOWPWR (6) if main_stop is set and LOW (5) if not; source is 3 and divide select is 0.
  - roc_sel gives ROC_LP (4) if main_stop is set and ROC (3) if not; source is 2 and the divider applies.
  - pll_on with pll_sel gives PLL (2); source is 1 and divide select is 0.
  - Otherwise the main clock drives the CPU; source is 0.
- R4: A write that changes div8 and also changes div_a or div_b is rejected with code 2.
- R5: pll_on and pll_sel must be written equal. PLL may be entered only from HIGH. Any write in which pll_on is 1 before or after may not change sub_sel, main_stop, roc_sel, div8, div_a or div_b. A write that breaks any of these is rejected with code 4.
- R6: wait1 may change only when pll_on is 0 both before and after the write. When pll_fast is high, PLL entry requires wait1=0. A write that breaks either rule is rejected with code 5.
- R7: A write that goes from ROC or ROC_LP to HIGH or MID is rejected with code 3 unless div8 is already 1.
- R8: When osd_en is 1, any write that changes main_stop is rejected with code 1.
- R9: When main_stop=1 and roc_sel=0, div8 and hi_drive are held at 1 and writes to them have no effect.
- R10: A write that moves onto the main clock (HIGH, MID or PLL) from another source is rejected with code 6 while main_stable is low. A write that moves onto the sub-clock (LOW or LOWPWR) from another source is rejected with code 6 while sub_stable is low.
- R11: A write that leaves main_stop=1 with both sub_sel=0 and roc_sel=0 is rejected with code 7.
- R12: A rejected write leaves the control word and the mode unchanged. It sets err_o and err_code_o for exactly the cycle after the write. An accepted write, or no write, gives err_o=0 and code 0.
- R13: When a write breaks more than one rule, the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | write strobe for the control word |
| wr_data | input | 11 | new control word |
| main_stable | input | 1 | main oscillator has settled |
| sub_stable | input | 1 | sub-clock oscillator has settled |
| pll_fast | input | 1 | PLL output is above 16 MHz |
| mode_o | output | 3 | current mode: 0 HIGH, 1 MID, 2 PLL, 3 ROC, 4 ROC_LP, 5 LOW, 6 LOWPWR |
| src_o | output | 2 | clock source: 0 main, 1 PLL, 2 on-chip, 3 sub |
| div_o | output | 3 | log2 of the divide ratio |
| wait_one_o | output | 1 | 1 = one flash wait state, 0 = two |
| ctrl_o | output | 11 | readback of the control word |
| err_o | output | 1 | one-cycle pulse for a rejected write |
| err_code_o | output | 3 | reason for the rejection, 0 when there is none |

## Verification
Several rejection reasons can apply to the same write, and one write can change the divider and the source together. The bench forces these cases on purpose. Two examples:
- A write that clears main_stop while osd_en is armed, and that also flips div8 with div_a. This must report the oscillation-stop reason and not the ordering reason.
- An attempt to enter the PLL with one wait state while pll_fast is high. This must fall on the wait-state rule, and in the same cycle the control word must stay frozen.

A behavioural model in the bench predicts the word, the mode and the error pair for every cycle. Any difference is reported under the requirement that the current phase exercises.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef struct packed {
        logic osd_en;
        logic hi_drive;
        logic wait1;
        logic pll_sel;
        logic pll_on;
        logic roc_sel;
        logic main_stop;
        logic sub_sel;
        logic div8;
        logic div_a;
        logic div_b;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int MODE_W = 3;
    localparam int SRC_W  = 2;
    localparam int DIV_W  = 3;
    localparam int CODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_HIGH   = 3'd0,
        MD_MID    = 3'd1,
        MD_PLL    = 3'd2,
        MD_ROC    = 3'd3,
        MD_ROC_LP = 3'd4,
        MD_LOW    = 3'd5,
        MD_LOWPWR = 3'd6
    } mode_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_ROC  = 2'd2,
        SRC_SUB  = 2'd3
    } src_e;

    typedef enum logic [CODE_W-1:0] {
        RJ_NONE     = 3'd0,
        RJ_OSD      = 3'd1,
        RJ_ORDER    = 3'd2,
        RJ_ROC_EXIT = 3'd3,
        RJ_PLL      = 3'd4,
        RJ_WAIT     = 3'd5,
        RJ_OSC      = 3'd6,
        RJ_NOCLK    = 3'd7
    } reject_e;

    localparam ctrl_t CTRL_RST = '{
        osd_en: 1'b0, hi_drive: 1'b1, wait1: 1'b0, pll_sel: 1'b0,
        pll_on: 1'b0, roc_sel: 1'b0, main_stop: 1'b0, sub_sel: 1'b0,
        div8: 1'b1, div_a: 1'b0, div_b: 1'b0
    };

    function automatic logic [DIV_W-1:0] div_log2(input ctrl_t c);
        logic [DIV_W-1:0] r;
        if (c.div8) begin
            r = 3'd3;
        end else begin
            unique case ({c.div_a, c.div_b})
                2'b00:   r = 3'd0;
                2'b01:   r = 3'd1;
                2'b10:   r = 3'd2;
                default: r = 3'd4;
            endcase
        end
        return r;
    endfunction

    function automatic logic on_main(input mode_e m);
        return (m == MD_HIGH) || (m == MD_MID) || (m == MD_PLL);
    endfunction

    function automatic logic on_sub(input mode_e m);
        return (m == MD_LOW) || (m == MD_LOWPWR);
    endfunction

    function automatic logic on_roc(input mode_e m);
        return (m == MD_ROC) || (m == MD_ROC_LP);
    endfunction

endpackage

// File: rtl/clkmode_decode.sv
module clkmode_decode
    import clkmode_pkg::*;
(
    input  ctrl_t cfg,
    output mode_e mode
);
    always_comb begin
        if (cfg.sub_sel) begin
            mode = cfg.main_stop ? MD_LOWPWR : MD_LOW;
        end else if (cfg.roc_sel) begin
            mode = cfg.main_stop ? MD_ROC_LP : MD_ROC;
        end else if (cfg.pll_on && cfg.pll_sel) begin
            mode = MD_PLL;
        end else if (div_log2(cfg) == '0) begin
            mode = MD_HIGH;
        end else begin
            mode = MD_MID;
        end
    end
endmodule

// File: rtl/clkmode_rules.sv
module clkmode_rules
    import clkmode_pkg::*;
(
    input  ctrl_t   cur,
    input  mode_e   cur_mode,
    input  ctrl_t   req,
    input  logic    main_stable,
    input  logic    sub_stable,
    input  logic    pll_fast,
    output ctrl_t   cand,
    output mode_e   cand_mode,
    output reject_e code
);
    logic f_osd, f_order, f_roc, f_pll, f_wait, f_osc, f_noclk;
    logic src_chg, pll_touch, pll_entry;

    // Low-power sub-clock state pins div8 and drive high
    always_comb begin
        cand = req;
        if (req.main_stop && !req.roc_sel) begin
            cand.div8     = 1'b1;
            cand.hi_drive = 1'b1;
        end
    end

    clkmode_decode u_dec (
        .cfg  (cand),
        .mode (cand_mode)
    );

    always_comb begin
        src_chg   = {cand.sub_sel, cand.main_stop, cand.roc_sel,
                     cand.div8, cand.div_a, cand.div_b}
                 != {cur.sub_sel, cur.main_stop, cur.roc_sel,
                     cur.div8, cur.div_a, cur.div_b};
        pll_touch = cur.pll_on || cand.pll_on;
        pll_entry = !cur.pll_on && cand.pll_on;

        f_osd   = cur.osd_en && (cand.main_stop != cur.main_stop);
        f_order = (cand.div8 != cur.div8)
               && ({cand.div_a, cand.div_b} != {cur.div_a, cur.div_b});
        f_roc   = on_roc(cur_mode)
               && ((cand_mode == MD_HIGH) || (cand_mode == MD_MID))
               && !cur.div8;
        f_pll   = (cand.pll_on != cand.pll_sel)
               || (pll_touch && src_chg)
               || (pll_entry && (cur_mode != MD_HIGH));
        f_wait  = ((cand.wait1 != cur.wait1) && pll_touch)
               || (pll_entry && pll_fast && cand.wait1);
        f_osc   = (on_main(cand_mode) && !on_main(cur_mode) && !main_stable)
               || (on_sub(cand_mode) && !on_sub(cur_mode) && !sub_stable);
        f_noclk = cand.main_stop && !cand.sub_sel && !cand.roc_sel;

        if (f_osd)         code = RJ_OSD;
        else if (f_order)  code = RJ_ORDER;
        else if (f_roc)    code = RJ_ROC_EXIT;
        else if (f_pll)    code = RJ_PLL;
        else if (f_wait)   code = RJ_WAIT;
        else if (f_osc)    code = RJ_OSC;
        else if (f_noclk)  code = RJ_NOCLK;
        else               code = RJ_NONE;
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              main_stable,
    input  logic              sub_stable,
    input  logic              pll_fast,
    output logic [MODE_W-1:0] mode_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              wait_one_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              err_o,
    output logic [CODE_W-1:0] err_code_o
);
    ctrl_t   ctrl_q;
    mode_e   state_q;
    logic    err_q;
    reject_e code_q;

    ctrl_t   cand;
    mode_e   cand_mode;
    reject_e code;

    clkmode_rules u_rules (
        .cur         (ctrl_q),
        .cur_mode    (state_q),
        .req         (ctrl_t'(wr_data)),
        .main_stable (main_stable),
        .sub_stable  (sub_stable),
        .pll_fast    (pll_fast),
        .cand        (cand),
        .cand_mode   (cand_mode),
        .code        (code)
    );

    // State register: control word, mode and error report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            state_q <= MD_MID;
            err_q   <= 1'b0;
            code_q  <= RJ_NONE;
        end else begin
            err_q  <= wr_en && (code != RJ_NONE);
            code_q <= wr_en ? code : RJ_NONE;
            if (wr_en && (code == RJ_NONE)) begin
                ctrl_q  <= cand;
                state_q <= cand_mode;
            end
        end
    end

    // Output process
    always_comb begin
        mode_o     = state_q;
        wait_one_o = ctrl_q.wait1;
        ctrl_o     = ctrl_q;
        err_o      = err_q;
        err_code_o = code_q;
        unique case (state_q)
            MD_HIGH, MD_MID: begin
                src_o = SRC_MAIN;
                div_o = div_log2(ctrl_q);
            end
            MD_PLL: begin
                src_o = SRC_PLL;
                div_o = '0;
            end
            MD_ROC, MD_ROC_LP: begin
                src_o = SRC_ROC;
                div_o = div_log2(ctrl_q);
            end
            MD_LOW, MD_LOWPWR: begin
                src_o = SRC_SUB;
                div_o = '0;
            end
            default: begin
                src_o = SRC_MAIN;
                div_o = div_log2(ctrl_q);
            end
        endcase
    end

    // R12
    reject_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (ctrl_q == $past(ctrl_q)));
    // R12
    err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(wr_en));
    // R12
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(ctrl_q));
    // R9
    lowpwr_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.main_stop && !ctrl_q.roc_sel) |-> (ctrl_q.div8 && ctrl_q.hi_drive));
    // R5
    pll_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.pll_on == ctrl_q.pll_sel);
    // R8
    osd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_q.osd_en) |-> (ctrl_q.main_stop == $past(ctrl_q.main_stop)));
    // R11
    clock_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.main_stop && !ctrl_q.sub_sel && !ctrl_q.roc_sel));
    // R6
    wait_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q.pll_on) && ctrl_q.pll_on) |-> $stable(ctrl_q.wait1));
endmodule

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;
    localparam int W = 11;
    localparam int B_DB = 0, B_DA = 1, B_D8 = 2, B_SUB = 3, B_MS = 4, B_ROC = 5;
    localparam int B_PON = 6, B_PSEL = 7, B_W1 = 8, B_HD = 9, B_OSD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         main_stable = 1'b1;
    logic         sub_stable = 1'b0;
    logic         pll_fast = 1'b0;
    logic [2:0]   mode_o;
    logic [1:0]   src_o;
    logic [2:0]   div_o;
    logic         wait_one_o;
    logic [W-1:0] ctrl_o;
    logic         err_o;
    logic [2:0]   err_code_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    clkmode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .main_stable(main_stable), .sub_stable(sub_stable), .pll_fast(pll_fast),
        .mode_o(mode_o), .src_o(src_o), .div_o(div_o), .wait_one_o(wait_one_o),
        .ctrl_o(ctrl_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    // Behavioural reference model
    logic [W-1:0] m_ctrl;
    int           m_mode;
    int           m_err;
    int           m_code;

    function automatic int ref_mode(logic [W-1:0] c);
        if (c[B_SUB]) return c[B_MS] ? 6 : 5;
        if (c[B_ROC]) return c[B_MS] ? 4 : 3;
        if (c[B_PON] && c[B_PSEL]) return 2;
        if (!c[B_D8] && c[B_DA] == 0 && c[B_DB] == 0) return 0;
        return 1;
    endfunction

    function automatic logic [W-1:0] forced(logic [W-1:0] c);
        logic [W-1:0] r = c;
        if (c[B_MS] && !c[B_ROC]) begin
            r[B_D8] = 1'b1;
            r[B_HD] = 1'b1;
        end
        return r;
    endfunction

    function automatic int ref_code(logic [W-1:0] o, logic [W-1:0] n, int om);
        int nm = ref_mode(n);
        int hits[$];
        bit srcd = (o[5:0] != n[5:0]);
        bit touch = o[B_PON] || n[B_PON];
        bit entry = !o[B_PON] && n[B_PON];
        if (n[B_MS] && !n[B_SUB] && !n[B_ROC]) hits.push_back(7);
        if (((nm <= 2) && (om > 2) && !main_stable) ||
            ((nm >= 5) && (om < 5) && !sub_stable)) hits.push_back(6);
        if (((o[B_W1] != n[B_W1]) && touch) || (entry && pll_fast && n[B_W1])) hits.push_back(5);
        if ((n[B_PON] != n[B_PSEL]) || (touch && srcd) || (entry && om != 0)) hits.push_back(4);
        if ((om == 3 || om == 4) && (nm <= 1) && !o[B_D8]) hits.push_back(3);
        if ((o[B_D8] != n[B_D8]) && (o[1:0] != n[1:0])) hits.push_back(2);
        if (o[B_OSD] && (o[B_MS] != n[B_MS])) hits.push_back(1);
        if (hits.size() == 0) return 0;
        return hits.min()[0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= 11'h204;
            m_mode <= 1;
            m_err  <= 0;
            m_code <= 0;
        end else begin
            int c;
            logic [W-1:0] nw;
            nw = forced(wr_data);
            c = wr_en ? ref_code(m_ctrl, nw, m_mode) : 0;
            m_err  <= (c != 0) ? 1 : 0;
            m_code <= c;
            if (wr_en && c == 0) begin
                m_ctrl <= nw;
                m_mode <= ref_mode(nw);
            end
        end
    end

    function automatic int ref_div(logic [W-1:0] c, int md);
        if (md == 2 || md >= 5) return 0;
        if (c[B_D8]) return 3;
        case (c[1:0])
            2'b00: return 0;
            2'b01: return 1;
            2'b10: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int ref_src(int md);
        if (md >= 5) return 3;
        if (md >= 3) return 2;
        if (md == 2) return 1;
        return 0;
    endfunction

    task automatic check(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("mode",  int'(mode_o), m_mode);
            check("src",   int'(src_o), ref_src(m_mode));
            check("div",   int'(div_o), ref_div(m_ctrl, m_mode));
            check("wait",  int'(wait_one_o), int'(m_ctrl[B_W1]));
            check("ctrl",  int'(ctrl_o), int'(m_ctrl));
            check("err",   int'(err_o), m_err);
            check("code",  int'(err_code_o), m_code);
        end
    end

    task automatic wr(logic [W-1:0] setm, logic [W-1:0] clrm);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = (m_ctrl | setm) & ~clrm;
        @(negedge clk);
        wr_en   = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] b(int i);
        return W'(1) << i;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check("reset ctrl", int'(ctrl_o), 'h204);
        check("reset mode", int'(mode_o), 1);
        check("reset div", int'(div_o), 3);

        tag = "R4";
        wr(b(B_DA), b(B_D8));
        check("order code", int'(m_code), 0);
        wr(b(B_DA), '0);
        tag = "R2";
        wr('0, b(B_D8));
        wr(b(B_DB), '0);
        wr('0, b(B_DA) | b(B_DB));
        check("high mode", int'(mode_o), 0);

        tag = "R5";
        wr(b(B_PON), '0);
        tag = "R6";
        wr(b(B_W1), '0);
        pll_fast = 1'b1;
        wr(b(B_PON) | b(B_PSEL), '0);
        wr('0, b(B_W1));
        tag = "R5";
        wr(b(B_PON) | b(B_PSEL), '0);
        check("pll mode", int'(mode_o), 2);
        tag = "R6";
        wr(b(B_W1), '0);
        tag = "R5";
        wr(b(B_DA), '0);
        wr('0, b(B_PON) | b(B_PSEL));
        pll_fast = 1'b0;
        wr(b(B_D8), '0);
        wr(b(B_PON) | b(B_PSEL), '0);

        tag = "R7";
        wr(b(B_ROC), '0);
        wr('0, b(B_D8));
        wr('0, b(B_ROC));
        wr(b(B_D8), '0);
        tag = "R10";
        main_stable = 1'b0;
        wr('0, b(B_ROC));
        main_stable = 1'b1;
        tag = "R7";
        wr('0, b(B_ROC));
        tag = "R10";
        wr(b(B_SUB), '0);
        sub_stable = 1'b1;
        wr(b(B_SUB), '0);
        check("low mode", int'(mode_o), 5);

        tag = "R9";
        wr(b(B_MS), '0);
        wr('0, b(B_D8) | b(B_HD));
        check("forced bits", int'(ctrl_o[B_D8] & ctrl_o[B_HD]), 1);

        tag = "R8";
        wr(b(B_OSD), '0);
        wr('0, b(B_MS));
        tag = "R13";
        wr(b(B_DA), b(B_MS) | b(B_D8));
        check("priority", int'(m_code), 0);
        tag = "R8";
        wr('0, b(B_OSD));

        tag = "R11";
        wr('0, b(B_SUB));
        tag = "R3";
        wr(b(B_ROC), '0);
        wr('0, b(B_SUB));
        check("roc lp mode", int'(mode_o), 4);
        wr('0, b(B_MS));
        tag = "R12";
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule